// File: doc/BRIEF.md
# SPI Slave With Request/Acknowledge Clock Crossing

This block is an SPI slave front end that runs directly on the serial clock supplied by the external master. It does not oversample that clock. While chip select is low it shifts in bytes from the master, most significant bit first. At the same time it shifts out a reply byte. The reply is the byte it most recently accepted.

Every completed byte is parked in a holding register on the serial-clock side. That side then raises a one-bit request flag. The system clock domain is faster and comes from an independent source. It sees the request through a two-flop synchronizer, emits a one-cycle valid strobe with the byte, and raises a one-bit acknowledge. The acknowledge returns through its own two-flop synchronizer. The exchange is four-phase: request up, acknowledge up, request down, acknowledge down. The parallel byte itself is never resynchronized bit by bit; it is read only while the request guarantees that it is stable.

The serial side only advances on serial clock edges. A handshake left open at the end of a frame therefore completes during the first edges of the next frame. A byte that finishes while the previous exchange is still open is dropped, and a sticky overrun flag is set.

Top module: `spi_hs_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `spi_overrun` is 0, and the holding register is zero. The first reply byte after reset is therefore 8'h00.
- R2: SPI mode 0 reception. `mosi` is sampled on each rising `sclk` edge while `cs_n` is low. The first bit received is bit 7 of the byte. Each accepted byte appears unchanged on `rx_data`.
- R3: Each accepted byte produces exactly one `rx_valid` pulse. The pulse is one `sys_clk` cycle wide. Bytes are delivered in the order they were received.
- R4: `rx_data` carries the accepted byte in the cycle where `rx_valid` is 1. The holding register does not change while the request is high.
- R5: `miso` is 0 whenever `cs_n` is high. While `cs_n` is low, `miso` returns the holding register most significant bit first. Bit 7 is valid from the falling edge of `cs_n`, and each following bit appears on a falling `sclk` edge.
- R6: Raising `cs_n` in the middle of a byte discards the partial bits. The next frame starts a fresh byte, and its reply restarts at bit 7.
- R7: A byte that completes while a handshake is in progress is discarded. It produces no `rx_valid` and leaves the holding register unchanged. It sets `spi_overrun`, which stays 1 until reset.
- R8: The request rises only when the synchronized acknowledge is low. The request falls only after the synchronized acknowledge has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, faster than and unrelated to `sclk` |
| sys_rst_n | input | 1 | Active-low synchronous reset, sampled by both clocks |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial reply data to the master, 0 when deselected |
| spi_overrun | output | 1 | Sticky flag set by a dropped byte (serial clock domain) |
| rx_valid | output | 1 | One-cycle strobe in `sys_clk` marking a new byte |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |

## Verification
Some properties are checked on every edge by the assertions:
- the four-phase ordering of request and synchronized acknowledge, on serial clock edges;
- the stability of the holding register while the request is high;
- the single-cycle width of the valid strobe;
- that overrun, once set, is sticky and leaves the held byte alone;
- that `miso` stays low while the slave is deselected.

Other behaviour only the bench scenarios can show. The bench compares the serial bit order in both directions and checks that the reply is the previous byte. It confirms that every byte appears exactly once and in order across two unrelated clocks with a random phase. It also shows that an aborted partial byte is discarded, and that a deliberately fast byte is dropped while the exchange is still open.

// File: rtl/spi_hs_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults for the SPI slave and its clock crossing.
// Assumes every user takes its widths from these constants unless overridden.
package spi_hs_pkg;
    localparam int unsigned HS_DATA_W   = 8;   // bits per serial byte
    localparam int unsigned HS_SYNC_LEN = 2;   // flops per flag synchronizer

    // Flag pair exchanged between the two clock domains.
    typedef struct packed {
        logic req;
        logic ack;
    } hs_flags_t;
endpackage

// File: rtl/spi_hs_sync.sv
`timescale 1ns/1ps
// Module: single-bit flag synchronizer.
// Carries one level signal into the clock domain of clk through STAGES flops.
// Every flop carries the sync_ prefix so all crossings can be found by text search.
// Assumes: STAGES >= 2, and d is a level that stays put long enough to be seen.
module spi_hs_sync #(
    parameter int unsigned STAGES = spi_hs_pkg::HS_SYNC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sync_stage_q;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_stage_q <= '0;
        end else begin
            sync_stage_q <= {sync_stage_q[STAGES-2:0], d};
        end
    end

    assign q = sync_stage_q[STAGES-1];
endmodule

// File: rtl/spi_hs_rx.sv
`timescale 1ns/1ps
// Module: serial-clock side of the slave (SPI mode 0).
// Shifts mosi in on rising sclk, MSB first, and drives miso from the holding
// register, changing on falling sclk. Owns the request flag of the handshake.
// Assumes: sclk idles low; rst_n is held across several sclk edges; the
// request is the only qualifier the other domain uses to read hold_q.
module spi_hs_rx #(
    parameter int unsigned DW   = spi_hs_pkg::HS_DATA_W,
    parameter int unsigned SYNC = spi_hs_pkg::HS_SYNC_LEN
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic          ack_async,
    output logic          miso,
    output logic          req_q,
    output logic          ack_seen,
    output logic [DW-1:0] hold_q,
    output logic          overrun_q
);
    localparam int unsigned       CW      = $clog2(DW);
    localparam logic [CW-1:0]     LAST_IX = CW'(DW - 1);

    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] tx_idx;
    logic [DW-1:0] shift_q;
    logic          byte_done;
    logic          busy;
    logic [DW-1:0] rx_byte;

    // Bring the acknowledge from the system domain into the serial domain.
    spi_hs_sync #(.STAGES(SYNC)) ack_sync_i (
        .clk   (sclk),
        .rst_n (rst_n),
        .d     (ack_async),
        .q     (ack_seen)
    );

    // Count received bits; deselecting clears the count at once.
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_cnt <= '0;
        end else begin
            bit_cnt <= (bit_cnt == LAST_IX) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Shift mosi in, most significant bit first.
    always_ff @(posedge sclk) begin
        if (!cs_n) begin
            shift_q <= {shift_q[DW-2:0], mosi};
        end
    end

    assign byte_done = !cs_n && (bit_cnt == LAST_IX);
    assign rx_byte   = {shift_q[DW-2:0], mosi};
    assign busy      = req_q || ack_seen;

    // Four-phase handshake: accept into hold when idle, drop request after ack.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            hold_q    <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (byte_done && !busy) begin
                hold_q <= rx_byte;
                req_q  <= 1'b1;
            end else if (req_q && ack_seen) begin
                req_q  <= 1'b0;
            end
            if (byte_done && busy) begin
                overrun_q <= 1'b1;
            end
        end
    end

    // Select the outgoing bit; advance on falling sclk, restart on deselect.
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            tx_idx <= '0;
        end else begin
            tx_idx <= (tx_idx == LAST_IX) ? '0 : tx_idx + 1'b1;
        end
    end

    assign miso = cs_n ? 1'b0 : hold_q[LAST_IX - tx_idx];
endmodule

// File: rtl/spi_hs_sys.sv
`timescale 1ns/1ps
// Module: system-clock side of the crossing.
// Synchronizes the request, answers it with an acknowledge that follows it,
// and on its synchronized rising edge captures the held byte with a one-cycle strobe.
// Assumes: hold_async is stable whenever req_async is high.
module spi_hs_sys #(
    parameter int unsigned DW   = spi_hs_pkg::HS_DATA_W,
    parameter int unsigned SYNC = spi_hs_pkg::HS_SYNC_LEN
) (
    input  logic          sys_clk,
    input  logic          rst_n,
    input  logic          req_async,
    input  logic [DW-1:0] hold_async,
    output logic          ack_q,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data
);
    logic req_seen;
    logic req_edge;

    // Bring the request from the serial domain into the system domain.
    spi_hs_sync #(.STAGES(SYNC)) req_sync_i (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_seen)
    );

    assign req_edge = req_seen && !ack_q;

    // Acknowledge follows the request; capture the byte on its new arrival.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            ack_q    <= req_seen;
            rx_valid <= req_edge;
            if (req_edge) begin
                rx_data <= hold_async;
            end
        end
    end
endmodule

// File: rtl/spi_hs_slave.sv
`timescale 1ns/1ps
// Module: top of the SPI slave with request/acknowledge byte crossing.
// Connects the serial-clock receiver to the system-clock consumer through
// single-bit flags only; the byte bus is read under the request's protection.
// Assumes: sys_clk is several times faster than sclk; sys_rst_n is held
// across a few edges of both clocks.
module spi_hs_slave #(
    parameter int unsigned DW   = spi_hs_pkg::HS_DATA_W,
    parameter int unsigned SYNC = spi_hs_pkg::HS_SYNC_LEN
) (
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    output logic          spi_overrun,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data
);
    spi_hs_pkg::hs_flags_t flags;
    logic                  ack_seen_w;
    logic [DW-1:0]         hold_w;

    spi_hs_rx #(.DW(DW), .SYNC(SYNC)) rx_i (
        .sclk      (sclk),
        .rst_n     (sys_rst_n),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .ack_async (flags.ack),
        .miso      (miso),
        .req_q     (flags.req),
        .ack_seen  (ack_seen_w),
        .hold_q    (hold_w),
        .overrun_q (spi_overrun)
    );

    spi_hs_sys #(.DW(DW), .SYNC(SYNC)) sys_i (
        .sys_clk    (sys_clk),
        .rst_n      (sys_rst_n),
        .req_async  (flags.req),
        .hold_async (hold_w),
        .ack_q      (flags.ack),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );
endmodule

// File: rtl/spi_hs_slave_chk.sv
`timescale 1ns/1ps
// Module: property checker for spi_hs_slave, attached by bind.
// Watches the handshake flags on serial edges and the strobe on system edges.
module spi_hs_slave_chk #(
    parameter int unsigned DW = spi_hs_pkg::HS_DATA_W
) (
    input logic          sys_clk,
    input logic          sys_rst_n,
    input logic          sclk,
    input logic          cs_n,
    input logic          miso,
    input logic          rx_valid,
    input logic          spi_req,
    input logic          spi_ack_seen,
    input logic [DW-1:0] hold,
    input logic          spi_overrun
);
    // R8
    req_rise_idle_chk: assert property (@(posedge sclk) disable iff (!sys_rst_n)
        $rose(spi_req) |-> !$past(spi_ack_seen));

    // R8
    req_fall_acked_chk: assert property (@(posedge sclk) disable iff (!sys_rst_n)
        $fell(spi_req) |-> $past(spi_ack_seen));

    // R4
    hold_stable_chk: assert property (@(posedge sclk) disable iff (!sys_rst_n)
        (spi_req && $past(spi_req)) |-> $stable(hold));

    // R7
    overrun_sticky_chk: assert property (@(posedge sclk) disable iff (!sys_rst_n)
        spi_overrun |=> spi_overrun);

    // R7
    overrun_hold_chk: assert property (@(posedge sclk) disable iff (!sys_rst_n)
        $rose(spi_overrun) |-> $stable(hold));

    // R3
    valid_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rx_valid |=> !rx_valid);

    // R5
    miso_idle_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cs_n |-> !miso);
endmodule

bind spi_hs_slave spi_hs_slave_chk #(.DW(DW)) chk_i (
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .miso         (miso),
    .rx_valid     (rx_valid),
    .spi_req      (flags.req),
    .spi_ack_seen (ack_seen_w),
    .hold         (hold_w),
    .spi_overrun  (spi_overrun)
);

// File: tb/spi_hs_slave_tb_top.sv
`timescale 1ns/1ps
module spi_hs_slave_tb_top;
    localparam real SYS_HALF  = 2.0;    // 250 MHz
    localparam real SPI_HALF  = 18.3;   // unrelated, non-integer ratio
    localparam real FAST_HALF = 0.4;    // deliberately faster than sys_clk

    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] reply;
    } vec_t;

    // Stimulus byte and expected reply (the previously accepted byte).
    localparam vec_t VEC [8] = '{
        '{8'hA5, 8'h00}, '{8'h3C, 8'hA5}, '{8'hFF, 8'h3C}, '{8'h00, 8'hFF},
        '{8'h81, 8'h00}, '{8'h7E, 8'h81}, '{8'h96, 8'h7E}, '{8'h01, 8'h96}
    };

    logic       sys_clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       spi_overrun;
    logic       rx_valid;
    logic [7:0] rx_data;

    int         n_chk = 0;
    int         n_bad = 0;
    int         got_n = 0;
    int         wide_pulse = 0;
    logic [7:0] got [32];
    logic       prev_valid = 1'b0;
    bit         done = 1'b0;

    always #(SYS_HALF) sys_clk = ~sys_clk;

    spi_hs_slave dut_i (
        .sys_clk     (sys_clk),
        .sys_rst_n   (sys_rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .miso        (miso),
        .spi_overrun (spi_overrun),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );

    // Record delivered bytes and strobes wider than one cycle (R3).
    always @(negedge sys_clk) begin
        if (rx_valid && got_n < 32) begin
            got[got_n] = rx_data;
            got_n = got_n + 1;
        end
        if (rx_valid && prev_valid) wide_pulse = wide_pulse + 1;
        prev_valid = rx_valid;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input real h, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            #(h);
            r[i] = miso;
            sclk = 1'b1;
            #(h);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        #(SPI_HALF);
    endtask

    task automatic frame_end();
        #(SPI_HALF);
        cs_n = 1'b1;
        #(SPI_HALF);
    endtask

    task automatic reset_seq();
        sys_rst_n = 1'b0;
        repeat (4) begin
            #(SPI_HALF) sclk = 1'b1;
            #(SPI_HALF) sclk = 1'b0;
        end
        repeat (3) @(posedge sys_clk);
        #0.5 sys_rst_n = 1'b1;
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(posedge sys_clk);
        #1;
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] r2;
        logic [7:0] r3;
        #($urandom_range(1, 97) * 0.137);
        reset_seq();
        wait_sys(2);
        check("R1 rx_valid after reset", rx_valid, 0);
        check("R1 spi_overrun after reset", spi_overrun, 0);
        check("R5 miso idle while deselected", miso, 0);

        // Vector table: one continuous frame.
        frame_start();
        for (int k = 0; k < 8; k++) begin
            send_byte(VEC[k].tx, SPI_HALF, r);
            check($sformatf("R5 reply byte %0d", k), r, VEC[k].reply);
        end
        frame_end();
        wait_sys(20);
        check("R3 delivered count after table", got_n, 8);
        for (int k = 0; k < 8; k++)
            check($sformatf("R2 received byte %0d", k), got[k], VEC[k].tx);
        check("R7 no overrun at normal rate", spi_overrun, 0);

        // R6: aborted partial byte, then a fresh frame.
        cs_n = 1'b0;
        #(SPI_HALF);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            #(SPI_HALF) sclk = 1'b1;
            #(SPI_HALF) sclk = 1'b0;
        end
        #(SPI_HALF) cs_n = 1'b1;
        #(SPI_HALF);
        frame_start();
        send_byte(8'hC3, SPI_HALF, r);
        frame_end();
        wait_sys(20);
        check("R6 reply restarts at bit 7", r, 8'h01);
        check("R6 delivered count after abort", got_n, 9);
        check("R6 byte after abort", got[8], 8'hC3);

        // R7: a fast byte completes while the handshake is still open.
        frame_start();
        send_byte(8'h5A, SPI_HALF, r);
        send_byte(8'hE7, FAST_HALF, r2);
        send_byte(8'h24, SPI_HALF, r3);
        frame_end();
        wait_sys(20);
        check("R5 reply before overrun", r, 8'hC3);
        check("R5 reply during fast byte", r2, 8'h5A);
        check("R7 hold unchanged by dropped byte", r3, 8'h5A);
        check("R7 overrun set", spi_overrun, 1);
        check("R7 delivered count with drop", got_n, 11);
        check("R7 byte before drop", got[9], 8'h5A);
        check("R7 byte after drop", got[10], 8'h24);

        // R1: reset again clears overrun and the holding register.
        reset_seq();
        wait_sys(2);
        check("R1 overrun cleared by reset", spi_overrun, 0);
        check("R1 rx_valid after second reset", rx_valid, 0);
        check("R5 miso idle after reset", miso, 0);
        frame_start();
        send_byte(8'h99, SPI_HALF, r);
        frame_end();
        wait_sys(20);
        check("R1 first reply after reset", r, 8'h00);
        check("R3 delivered count final", got_n, 12);
        check("R2 byte after reset", got[11], 8'h99);
        check("R3 strobe width one cycle", wide_pulse, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule